// File: doc/BRIEF.md
# Serial Channel Status Flags and Interrupt Requests

This block keeps the status flags and the interrupt-request logic of one asynchronous serial channel. A receiver and a transmit shifter elsewhere report events to it: a completed frame together with the sampled stop bit, a receive-data-full level, overrun and parity-error levels, and a pulse for each move of a byte from the transmit data register into the transmit shifter. The CPU writes the interrupt enables and the pin-function bit through a status-register write, clears the error flags through a control-register write, and loads the transmit data register through its own write strobe.

The block reads in two modem lines. The carrier-detect line clears the framing error while it is high, and its rising edge raises a receive interrupt. The clear-to-send line shares a package pin with the receive data of a clocked serial port. A control bit picks which function that pin serves. When the pin serves as clear-to-send and the line is high, the transmit-empty flag reads as 0. An I/O-stop mode input clears the framing error and forces transmit-empty to 1. Both external lines pass through synchronizers before any logic uses them.

Top module: `sio_stat_irq`

## Requirements
- R1: One cycle after a `frame_done` pulse with `stop_bit` low, status bit 4 (framing error) reads 1, provided no clear condition is active in that cycle. A frame whose stop bit samples high leaves the flag unchanged.
- R2: The framing-error flag goes to 0 on the next edge when any of these hold: `ctrl_wr` with `ctrl_efr`=0, synchronized `dcd_pin` high, `iostop` high. It is also 0 during reset. A clear in the same cycle as a set event wins.
- R3: `rx_irq` is 1 exactly when status bit 3 (receive-interrupt enable) is 1 and at least one of `rx_full`, `rx_overrun`, `rx_parity_err`, the framing-error flag or the latched carrier-detect event is 1.
- R4: A low-to-high change of `dcd_pin`, after a two-flop synchronizer, sets a latched event 3 edges after the pin rises. The event stays set after the pin falls and is cleared only by `ctrl_wr` with `ctrl_efr`=0 or by reset.
- R5: Status bit 2 (pin select) drives `pin_is_cts`. When it is 1, `shr_pin` acts as clear-to-send and `csio_rxd` is held at 1. When it is 0, `csio_rxd` follows `shr_pin` and clear-to-send counts as inactive.
- R6: Status bit 1 (transmit-data empty) goes to 0 after `tdr_wr` and to 1 after `tx_xfer`. When both arrive in the same cycle, the write wins.
- R7: Transmit-data empty is 1 after reset and is forced to 1 while `iostop` is high. With `pin_is_cts`=1 and `shr_pin` high, it reads 0 from the second edge onward, unless `iostop` is high.
- R8: `tx_irq` is 1 exactly when status bit 0 (transmit-interrupt enable) and transmit-data empty are both 1.
- R9: The status layout is: bit 4 framing error, bit 3 receive-interrupt enable, bit 2 pin select, bit 1 transmit-data empty, bit 0 transmit-interrupt enable, bits 7:5 read 0. A `stat_wr` loads bits 3, 2 and 0 from `wr_data` and leaves bits 4 and 1 unchanged. Reset clears all three enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_done | input | 1 | Receiver finished a frame this cycle |
| stop_bit | input | 1 | Sampled stop bit of that frame |
| rx_full | input | 1 | Receive data register holds a byte |
| rx_overrun | input | 1 | Receiver overrun flag |
| rx_parity_err | input | 1 | Receiver parity-error flag |
| tx_xfer | input | 1 | Byte moved from transmit data register to shifter |
| stat_wr | input | 1 | CPU write to the status byte |
| wr_data | input | 8 | Data for the status write |
| ctrl_wr | input | 1 | CPU write to the control register |
| ctrl_efr | input | 1 | Error-flag-reset bit of that write; 0 clears |
| tdr_wr | input | 1 | CPU write to the transmit data register |
| dcd_pin | input | 1 | Carrier-detect line, asynchronous |
| shr_pin | input | 1 | Shared clear-to-send / serial-data pin, asynchronous |
| iostop | input | 1 | I/O-stop mode |
| status | output | 8 | Status byte |
| rx_irq | output | 1 | Receive interrupt request |
| tx_irq | output | 1 | Transmit interrupt request |
| pin_is_cts | output | 1 | Shared pin serves as clear-to-send |
| csio_rxd | output | 1 | Receive data routed to the clocked serial port |

## Verification
Each receive source is raised on its own with the receive enable set, and again with the enable cleared. This shows that the request follows every source and that the enable masks each one. The framing flag is hit with set and clear events in the same cycle, with a good stop bit, and with an error-reset write carrying a 1. These cases separate "clear wins" from "set wins" and show that a write with a 1 has no effect. Transmit-empty is driven through write, transfer, write plus transfer, I/O stop plus write, and a clear-to-send level that is high with the pin select on and with it off. This tells the gating, its two-edge delay and the I/O-stop override apart. The carrier-detect test checks that the rising-edge request appears only on the third edge, survives the pin falling, and stops a framing error from setting while the line is high.

// File: rtl/sio_stat_pkg.sv
package sio_stat_pkg;
    localparam int STAT_W      = 8;
    localparam int SYNC_STAGES = 2;
    localparam int BIT_FE      = 4;
    localparam int BIT_RIE     = 3;
    localparam int BIT_CTSEN   = 2;
    localparam int BIT_TDRE    = 1;
    localparam int BIT_TIE     = 0;

    typedef struct packed {
        logic rie;
        logic cts_en;
        logic tie;
    } sio_ctrl_t;

    typedef struct packed {
        logic fe;
        logic dcd_prev;
        logic dcd_evt;
    } sio_rxf_t;
endpackage

// File: rtl/sio_sync.sv
module sio_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/sio_rx_flags.sv
module sio_rx_flags
    import sio_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_done,
    input  logic stop_bit,
    input  logic efr_clr,
    input  logic dcd_hi,
    input  logic iostop,
    output logic fe,
    output logic dcd_evt
);
    sio_rxf_t r_d, r_q;
    logic     fe_clr;
    logic     dcd_rise;

    always_comb begin
        r_d      = r_q;
        fe_clr   = efr_clr | dcd_hi | iostop;
        dcd_rise = dcd_hi & ~r_q.dcd_prev;
        r_d.dcd_prev = dcd_hi;
        // clear dominates the set event
        if (fe_clr)                        r_d.fe = 1'b0;
        else if (frame_done && !stop_bit)  r_d.fe = 1'b1;
        if (efr_clr)                       r_d.dcd_evt = 1'b0;
        else if (dcd_rise)                 r_d.dcd_evt = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign fe      = r_q.fe;
    assign dcd_evt = r_q.dcd_evt;
endmodule

// File: rtl/sio_tx_flag.sv
module sio_tx_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic tdr_wr,
    input  logic xfer,
    input  logic iostop,
    input  logic cts_block,
    output logic tdre
);
    logic empty_d, empty_q;

    always_comb begin
        empty_d = empty_q;
        if (iostop)      empty_d = 1'b1;
        else if (tdr_wr) empty_d = 1'b0;
        else if (xfer)   empty_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) empty_q <= 1'b1;
        else        empty_q <= empty_d;
    end

    assign tdre = empty_q & (~cts_block | iostop);
endmodule

// File: rtl/sio_stat_irq.sv
module sio_stat_irq
    import sio_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_done,
    input  logic              stop_bit,
    input  logic              rx_full,
    input  logic              rx_overrun,
    input  logic              rx_parity_err,
    input  logic              tx_xfer,
    input  logic              stat_wr,
    input  logic [STAT_W-1:0] wr_data,
    input  logic              ctrl_wr,
    input  logic              ctrl_efr,
    input  logic              tdr_wr,
    input  logic              dcd_pin,
    input  logic              shr_pin,
    input  logic              iostop,
    output logic [STAT_W-1:0] status,
    output logic              rx_irq,
    output logic              tx_irq,
    output logic              pin_is_cts,
    output logic              csio_rxd
);
    sio_ctrl_t ctl_d, ctl_q;
    logic      dcd_hi, cts_hi, cts_block;
    logic      efr_clr, fe, dcd_evt, tdre;

    sio_sync #(.STAGES(SYNC_STAGES)) u_dcd_sync (
        .clk(clk), .rst_n(rst_n), .din(dcd_pin), .dout(dcd_hi)
    );
    sio_sync #(.STAGES(SYNC_STAGES)) u_cts_sync (
        .clk(clk), .rst_n(rst_n), .din(shr_pin), .dout(cts_hi)
    );

    assign efr_clr   = ctrl_wr & ~ctrl_efr;
    assign cts_block = ctl_q.cts_en & cts_hi;

    sio_rx_flags u_rxf (
        .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .stop_bit(stop_bit),
        .efr_clr(efr_clr), .dcd_hi(dcd_hi), .iostop(iostop),
        .fe(fe), .dcd_evt(dcd_evt)
    );

    sio_tx_flag u_txf (
        .clk(clk), .rst_n(rst_n), .tdr_wr(tdr_wr), .xfer(tx_xfer),
        .iostop(iostop), .cts_block(cts_block), .tdre(tdre)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (stat_wr) begin
            ctl_d.rie    = wr_data[BIT_RIE];
            ctl_d.cts_en = wr_data[BIT_CTSEN];
            ctl_d.tie    = wr_data[BIT_TIE];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        status             = '0;
        status[BIT_FE]     = fe;
        status[BIT_RIE]    = ctl_q.rie;
        status[BIT_CTSEN]  = ctl_q.cts_en;
        status[BIT_TDRE]   = tdre;
        status[BIT_TIE]    = ctl_q.tie;
    end

    assign rx_irq     = ctl_q.rie & (rx_full | rx_overrun | rx_parity_err | fe | dcd_evt);
    assign tx_irq     = ctl_q.tie & tdre;
    assign pin_is_cts = ctl_q.cts_en;
    assign csio_rxd   = ctl_q.cts_en ? 1'b1 : shr_pin;
endmodule

// File: rtl/sio_stat_irq_chk.sv
module sio_stat_irq_chk
    import sio_stat_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              frame_done,
    input logic              stop_bit,
    input logic              rx_full,
    input logic              ctrl_wr,
    input logic              ctrl_efr,
    input logic              tdr_wr,
    input logic              iostop,
    input logic              stat_wr,
    input logic [STAT_W-1:0] wr_data,
    input logic              dcd_hi,
    input logic [STAT_W-1:0] status,
    input logic              rx_irq,
    input logic              tx_irq
);
    p_fe_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !stop_bit && !(ctrl_wr && !ctrl_efr) && !dcd_hi && !iostop)
        |=> status[BIT_FE]);

    p_fe_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctrl_wr && !ctrl_efr) || iostop) |=> !status[BIT_FE]);

    p_rie_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !status[BIT_RIE] |-> !rx_irq);

    p_rx_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (status[BIT_RIE] && rx_full) |-> rx_irq);

    p_tdr_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tdr_wr && !iostop) |=> !status[BIT_TDRE]);

    p_iostop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (iostop && $past(iostop)) |-> status[BIT_TDRE]);

    p_tx_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (status[BIT_TIE] && status[BIT_TDRE]) |-> tx_irq);

    p_tx_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |-> status[BIT_TIE]);

    p_wr_rie_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |=> (status[BIT_RIE] == $past(wr_data[BIT_RIE])));
endmodule

bind sio_stat_irq sio_stat_irq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .stop_bit(stop_bit),
    .rx_full(rx_full), .ctrl_wr(ctrl_wr), .ctrl_efr(ctrl_efr), .tdr_wr(tdr_wr),
    .iostop(iostop), .stat_wr(stat_wr), .wr_data(wr_data), .dcd_hi(dcd_hi),
    .status(status), .rx_irq(rx_irq), .tx_irq(tx_irq)
);

// File: tb/sio_stat_irq_tb.sv
`timescale 1ns/1ps
module sio_stat_irq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_done = 0, stop_bit = 1, rx_full = 0, rx_overrun = 0, rx_parity_err = 0;
    logic       tx_xfer = 0, stat_wr = 0, ctrl_wr = 0, ctrl_efr = 1, tdr_wr = 0;
    logic       dcd_pin = 0, shr_pin = 0, iostop = 0;
    logic [7:0] wr_data = '0;
    logic [7:0] status;
    logic       rx_irq, tx_irq, pin_is_cts, csio_rxd;
    int         checks = 0;
    int         errors = 0;
    logic       done = 1'b0;

    always #2.5 clk = ~clk;

    sio_stat_irq u_dut (
        .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .stop_bit(stop_bit),
        .rx_full(rx_full), .rx_overrun(rx_overrun), .rx_parity_err(rx_parity_err),
        .tx_xfer(tx_xfer), .stat_wr(stat_wr), .wr_data(wr_data), .ctrl_wr(ctrl_wr),
        .ctrl_efr(ctrl_efr), .tdr_wr(tdr_wr), .dcd_pin(dcd_pin), .shr_pin(shr_pin),
        .iostop(iostop), .status(status), .rx_irq(rx_irq), .tx_irq(tx_irq),
        .pin_is_cts(pin_is_cts), .csio_rxd(csio_rxd)
    );

    typedef struct packed {
        logic       sw;
        logic [7:0] wd;
        logic       cw, efr, tw, xf, fd, sb, rf, ov, pe, io;
        logic [7:0] st;
        logic       rxi, txi;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t TBL [NV] = '{
        // sw   wd     cw   efr  tw   xf   fd   sb   rf   ov   pe   io   st     rxi  txi  req
        '{1'b1,8'h09,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,8'h0B,1'b0,1'b1,4'd9}, // R9 enables
        '{1'b0,8'h00,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,8'h09,1'b0,1'b0,4'd6}, // R6 write
        '{1'b0,8'h00,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,8'h0B,1'b0,1'b1,4'd6}, // R6 transfer
        '{1'b0,8'h00,1'b0,1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,8'h09,1'b0,1'b0,4'd6}, // R6 write wins
        '{1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,8'h19,1'b1,1'b0,4'd1}, // R1 bad stop
        '{1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,8'h19,1'b1,1'b0,4'd3}, // R3 held
        '{1'b0,8'h00,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,8'h09,1'b0,1'b0,4'd2}, // R2 efr clear
        '{1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,8'h09,1'b0,1'b0,4'd1}, // R1 good stop
        '{1'b0,8'h00,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,8'h09,1'b0,1'b0,4'd2}, // R2 clear wins
        '{1'b0,8'h00,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,8'h19,1'b1,1'b0,4'd2}, // R2 efr=1 no clear
        '{1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,8'h0B,1'b0,1'b1,4'd7}, // R7 iostop
        '{1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,8'h0B,1'b1,1'b1,4'd3}, // R3 overrun
        '{1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,8'h0B,1'b1,1'b1,4'd3}, // R3 parity
        '{1'b1,8'h00,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,8'h02,1'b0,1'b0,4'd3}, // R3 masked
        '{1'b1,8'hFF,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,8'h0F,1'b0,1'b1,4'd9}, // R9 ro bits
        '{1'b0,8'h00,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,8'h0F,1'b0,1'b1,4'd7}, // R7 iostop wins
        '{1'b1,8'h08,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,8'h0A,1'b0,1'b0,4'd8}  // R8 tie off
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        stat_wr = 0; wr_data = '0; ctrl_wr = 0; ctrl_efr = 1; tdr_wr = 0; tx_xfer = 0;
        frame_done = 0; stop_bit = 1; rx_full = 0; rx_overrun = 0; rx_parity_err = 0; iostop = 0;
    endtask

    task automatic step();
        @(posedge clk); #1;
        @(negedge clk); idle();
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle();
        #12;
        // R9 R7 reset state
        chk("R9 reset status", status, 8'h02);
        chk("R8 reset tx_irq", {7'd0, tx_irq}, 8'h00);
        @(negedge clk); rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            stat_wr = TBL[i].sw; wr_data = TBL[i].wd; ctrl_wr = TBL[i].cw; ctrl_efr = TBL[i].efr;
            tdr_wr = TBL[i].tw; tx_xfer = TBL[i].xf; frame_done = TBL[i].fd; stop_bit = TBL[i].sb;
            rx_full = TBL[i].rf; rx_overrun = TBL[i].ov; rx_parity_err = TBL[i].pe; iostop = TBL[i].io;
            @(posedge clk); #1;
            chk($sformatf("R%0d vec %0d status", TBL[i].req, i), status, TBL[i].st);
            chk($sformatf("R%0d vec %0d irqs", TBL[i].req, i),
                {6'd0, rx_irq, tx_irq}, {6'd0, TBL[i].rxi, TBL[i].txi});
        end
        @(negedge clk); idle();

        // R4 carrier-detect edge; rie=1, no flags
        dcd_pin = 1'b1;
        step();
        chk("R4 no irq after 1 edge", {7'd0, rx_irq}, 8'h00);
        @(posedge clk); #1;
        chk("R4 no irq after 2 edges", {7'd0, rx_irq}, 8'h00);
        @(posedge clk); #1;
        chk("R4 irq after 3 edges", {7'd0, rx_irq}, 8'h01);
        // R2 dcd high blocks framing error
        @(negedge clk); frame_done = 1; stop_bit = 0;
        step();
        chk("R2 fe held clear by dcd", {7'd0, status[4]}, 8'h00);
        dcd_pin = 1'b0;
        repeat (3) step();
        chk("R4 event survives dcd fall", {7'd0, rx_irq}, 8'h01);
        ctrl_wr = 1; ctrl_efr = 0;
        step();
        chk("R4 event cleared by efr write", {7'd0, rx_irq}, 8'h00);

        // R5 R7 clear-to-send gating
        stat_wr = 1; wr_data = 8'h05;
        step();
        chk("R5 pin select on", {6'd0, pin_is_cts, csio_rxd}, 8'h03);
        chk("R7 tdre with cts low", {7'd0, status[1]}, 8'h01);
        shr_pin = 1'b1;
        @(posedge clk); #1;
        chk("R7 tdre after 1 edge", {7'd0, status[1]}, 8'h01);
        @(posedge clk); #1;
        chk("R7 tdre blocked by cts", {7'd0, status[1]}, 8'h00);
        chk("R8 tx_irq blocked by cts", {7'd0, tx_irq}, 8'h00);
        @(negedge clk); iostop = 1;
        @(posedge clk); #1;
        chk("R7 iostop overrides cts", {7'd0, status[1]}, 8'h01);
        @(negedge clk); idle();
        @(posedge clk); #1;
        chk("R7 cts blocks again", {7'd0, status[1]}, 8'h00);
        @(negedge clk); stat_wr = 1; wr_data = 8'h01;
        @(posedge clk); #1;
        chk("R5 pin select off frees tdre", {6'd0, pin_is_cts, status[1]}, 8'h01);
        chk("R5 csio_rxd follows pin high", {7'd0, csio_rxd}, 8'h01);
        @(negedge clk); idle(); shr_pin = 1'b0; #1;
        chk("R5 csio_rxd follows pin low", {7'd0, csio_rxd}, 8'h00);

        // R9 R2 reset mid-run
        frame_done = 1; stop_bit = 0; tdr_wr = 1;
        step();
        chk("R1 fe set before reset", status, 8'h11);
        rst_n = 1'b0; #1;
        chk("R9 status in reset", status, 8'h02);
        @(negedge clk); rst_n = 1'b1;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule